// File: doc/BRIEF.md
# Peripheral clock-stop handshake

This block lets software stop the clock of a single peripheral and lets the hardware start it again. Software writes a key-protected request bit. The block then raises a stop request toward the peripheral and waits for the peripheral to acknowledge it. Only after that acknowledge does the block drop the peripheral's clock enable.

The clock comes back on in one of two ways. A wake event from the peripheral side restarts it while it is stopped, and the block clears the pending request by itself in the same step. Software can also release the request with a keyed write of zero. Every wake event sets a sticky status flag, which stays set until software clears it through a write-one-to-clear word.

Register access is a single-cycle write port plus a combinational read port, indexed by a 2-bit word address:

| Word | Contents |
|---|---|
| 0 | Request |
| 1 | Acknowledge |
| 2 | Wake status |
| 3 | Wake clear |

Each word carries its flag in bit 0, and the key occupies bits 31:16.

Top module: `cs_handshake_top`

## Requirements
- R1: After reset `clk_en_o` is 1, `stop_req_o` is 0, and words 0, 1, 2 and 3 all read 0.
- R2: A write to word 0 with 0x5634 in bits 31:16 and bit 0 = 1 sets the request. `stop_req_o` and word 0 bit 0 read 1 after that clock edge.
- R3: A write to word 0 whose bits 31:16 differ from 0x5634 changes neither the request nor the clock enable.
- R4: `clk_en_o` falls at the first clock edge where the request is already pending and `stop_ack_i` is 1. It never falls otherwise.
- R5: Word 1 bit 0 reads 1 exactly when a request is pending and `stop_ack_i` is 1.
- R6: `wake_i` while the clock is stopped makes `clk_en_o` 1 and clears the request at that edge.
- R7: `wake_i` while the clock is still running leaves a pending request set.
- R8: A keyed write to word 0 with bit 0 = 0 clears the request and turns the clock on if it was stopped.
- R9: `wake_i` sets the wake status, read at word 2 bit 0, and the status stays set until it is cleared.
- R10: Writing 1 to bit 0 of word 3 clears the wake status. Writing 0 there has no effect, and word 3 always reads 0.
- R11: When `wake_i` and a status-clear write fall in the same cycle, the status stays set.
- R12: When `wake_i` and a keyed set write fall in the same cycle while the clock is stopped, the wake wins: the clock turns on and the request ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address for both write and read |
| reg_wdata_i | input | 32 | Write data; key in 31:16, flag in bit 0 |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| stop_req_o | output | 1 | Clock-stop request to the peripheral |
| stop_ack_i | input | 1 | Stop acknowledge from the peripheral |
| wake_i | input | 1 | Wake event from the peripheral side |
| clk_en_o | output | 1 | Enable for the peripheral's clock gate |

## Verification
The request, clock-enable and wake-status state all change at the clock edge that samples the write, acknowledge or wake input. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and checks `stop_req_o`, `clk_en_o` and the readback on the following falling edge.

Stopping the clock costs one more edge after the request is set, because the acknowledge only counts once the request is already registered. The vector table encodes that gap row by row.

The acknowledge word is combinational from the live acknowledge input, so it is read one time step after the input changes, with no edge in between.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    CS_REQ = 2'd0,
    CS_ACK = 2'd1,
    CS_STS = 2'd2,
    CS_CLR = 2'd3
  } cs_word_e;

  localparam int unsigned CS_DATA_W = 32;
  localparam int unsigned CS_KEY_W  = 16;
  localparam logic [15:0] CS_KEY    = 16'h5634;
endpackage

// File: rtl/cs_wr_decode.sv
module cs_wr_decode
  import cs_pkg::*;
#(
  parameter int unsigned DATA_W  = CS_DATA_W,
  parameter int unsigned KEY_W   = CS_KEY_W,
  parameter logic [KEY_W-1:0] KEY_VAL = CS_KEY
) (
  input  logic              wr_i,
  input  cs_word_e          addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              set_req_o,
  output logic              rel_req_o,
  output logic              clr_sts_o
);
  localparam int unsigned KEY_LSB = DATA_W - KEY_W;

  logic key_ok;
  logic req_wr;

  assign key_ok    = (wdata_i[DATA_W-1:KEY_LSB] == KEY_VAL);
  assign req_wr    = wr_i && (addr_i == CS_REQ) && key_ok;
  assign set_req_o = req_wr &&  wdata_i[0];
  assign rel_req_o = req_wr && !wdata_i[0];
  // clear word needs no key
  assign clr_sts_o = wr_i && (addr_i == CS_CLR) && wdata_i[0];

  logic unused_bits;
  assign unused_bits = ^wdata_i[KEY_LSB-1:1];
endmodule

// File: rtl/cs_stop_ctrl.sv
module cs_stop_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_req_i,
  input  logic rel_req_i,
  input  logic stop_ack_i,
  input  logic wake_i,
  output logic req_o,
  output logic clk_en_o
);
  logic req_q, clk_en_q;
  logic req_d, clk_en_d;
  logic restart;

  // wake only restarts a stopped clock; release works in any state
  assign restart = (wake_i && !clk_en_q) || rel_req_i;

  always_comb begin
    req_d    = req_q;
    clk_en_d = clk_en_q;
    if (restart) begin
      req_d    = 1'b0;
      clk_en_d = 1'b1;
    end else begin
      if (set_req_i)             req_d    = 1'b1;
      if (req_q && stop_ack_i)   clk_en_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      clk_en_q <= 1'b1;
    end else begin
      req_q    <= req_d;
      clk_en_q <= clk_en_d;
    end
  end

  assign req_o    = req_q;
  assign clk_en_o = clk_en_q;

  AST_STOP_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_q) |-> $past(req_q && stop_ack_i)); // R4
  AST_STOP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && stop_ack_i && clk_en_q && !rel_req_i) |=> !clk_en_q); // R4
  AST_WAKE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !clk_en_q) |=> (clk_en_q && !req_q)); // R6
  AST_WAKE_RUNNING_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && clk_en_q && req_q && !rel_req_i) |=> req_q); // R7
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_req_i |=> (clk_en_q && !req_q)); // R8
endmodule

// File: rtl/cs_wake_flag.sv
module cs_wake_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (wake_i) sts_q <= 1'b1;
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o = sts_q;

  AST_WAKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> sts_q); // R9
  AST_HOLD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !clr_i) |=> sts_q); // R9
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wake_i) |=> !sts_q); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && wake_i) |=> sts_q); // R11
endmodule

// File: rtl/cs_handshake_top.sv
module cs_handshake_top
  import cs_pkg::*;
#(
  parameter int unsigned DATA_W  = CS_DATA_W,
  parameter int unsigned KEY_W   = CS_KEY_W,
  parameter logic [KEY_W-1:0] KEY_VAL = CS_KEY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              stop_req_o,
  input  logic              stop_ack_i,
  input  logic              wake_i,
  output logic              clk_en_o
);
  localparam int unsigned KEY_LSB = DATA_W - KEY_W;

  cs_word_e word;
  logic set_req, rel_req, clr_sts;
  logic req, sts;

  assign word = cs_word_e'(reg_addr_i);

  cs_wr_decode #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_dec (
    .wr_i      (reg_wr_i),
    .addr_i    (word),
    .wdata_i   (reg_wdata_i),
    .set_req_o (set_req),
    .rel_req_o (rel_req),
    .clr_sts_o (clr_sts)
  );

  cs_stop_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_req_i  (set_req),
    .rel_req_i  (rel_req),
    .stop_ack_i (stop_ack_i),
    .wake_i     (wake_i),
    .req_o      (req),
    .clk_en_o   (clk_en_o)
  );

  cs_wake_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wake_i (wake_i),
    .clr_i  (clr_sts),
    .sts_o  (sts)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (word)
      CS_REQ:  reg_rdata_o[0] = req;
      CS_ACK:  reg_rdata_o[0] = req && stop_ack_i;
      CS_STS:  reg_rdata_o[0] = sts;
      default: reg_rdata_o    = '0;
    endcase
  end

  assign stop_req_o = req;

  AST_KEY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[DATA_W-1:KEY_LSB] != KEY_VAL && !wake_i)
      |=> $stable(stop_req_o)); // R3
  AST_KEYED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[DATA_W-1:KEY_LSB] == KEY_VAL &&
     reg_wdata_i[0] && !wake_i) |=> stop_req_o); // R2

  always_comb begin
    if (rst_ni && reg_addr_i == 2'd3)
      AST_CLR_READS_ZERO: assert (reg_rdata_o == '0); // R10
  end
endmodule

// File: tb/tb_cs_handshake_top.sv
`timescale 1ns/1ps
module tb_cs_handshake_top;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        sreq, ack, wake, en;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cs_handshake_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stop_req_o(sreq),
    .stop_ack_i(ack), .wake_i(wake), .clk_en_o(en)
  );

  // {wr, addr, wdata, ack, wake, exp_en, exp_req}
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 2'd0, 32'h5634_0001, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 keyed set
    {1'b0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1}, // R4 no ack, keep running
    {1'b0, 2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1}, // R4 ack stops clock
    {1'b0, 2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1},
    {1'b0, 2'd0, 32'h0,         1'b1, 1'b1, 1'b1, 1'b0}, // R6 wake restarts
    {1'b0, 2'd0, 32'h0,         1'b1, 1'b0, 1'b1, 1'b0},
    {1'b1, 2'd0, 32'h1234_0001, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 wrong key
    {1'b1, 2'd0, 32'h5634_0001, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b0, 2'd0, 32'h0,         1'b0, 1'b1, 1'b1, 1'b1}, // R7 wake while running
    {1'b1, 2'd0, 32'h5634_0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 withdraw
    {1'b1, 2'd0, 32'h5634_0001, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 ack before req registered
    {1'b0, 2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 2'd0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 unkeyed release
    {1'b1, 2'd0, 32'h5634_0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R8 release restarts
    {1'b1, 2'd0, 32'h5634_0001, 1'b1, 1'b0, 1'b1, 1'b1},
    {1'b0, 2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 2'd0, 32'h5634_0001, 1'b1, 1'b1, 1'b1, 1'b0}, // R12 wake beats set
    {1'b0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // inputs applied at a falling edge, one rising edge, results seen at next falling edge
  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic k, input logic wk);
    wr = w; addr = a; wdata = d; ack = k; wake = wk;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wake = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr = 1'b0; addr = 2'd0; wdata = '0; ack = 1'b0; wake = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 clk_en", {31'b0, en}, 32'd1);
    chk("R1 stop_req", {31'b0, sreq}, 32'd0);
    for (int w = 0; w < 4; w++) rd(2'(w), 32'd0, "R1 readback");

    // table: R2 R3 R4 R6 R7 R8 R12
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][38], VEC[i][37:36], VEC[i][35:4], VEC[i][3], VEC[i][2]);
      chk($sformatf("vec %0d clk_en (R2 R3 R4 R6 R7 R8 R12)", i), {31'b0, en}, {31'b0, VEC[i][1]});
      chk($sformatf("vec %0d stop_req (R2 R3 R4 R6 R7 R8 R12)", i), {31'b0, sreq}, {31'b0, VEC[i][0]});
    end

    // R2 readback, R5 acknowledge word
    do_reset();
    cyc(1'b1, 2'd0, 32'h5634_0001, 1'b0, 1'b0);
    rd(2'd0, 32'd1, "R2 request readback");
    rd(2'd1, 32'd0, "R5 ack low");
    ack = 1'b1;
    rd(2'd1, 32'd1, "R5 ack with request");
    cyc(1'b1, 2'd0, 32'h5634_0000, 1'b1, 1'b0);
    rd(2'd1, 32'd0, "R5 ack without request");

    // R9 R10 R11 wake status
    do_reset();
    rd(2'd2, 32'd0, "R9 status after reset");
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    rd(2'd2, 32'd1, "R9 status set");
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b0);
    rd(2'd2, 32'd1, "R9 status sticky");
    cyc(1'b1, 2'd3, 32'h0000_0000, 1'b0, 1'b0);
    rd(2'd2, 32'd1, "R10 write 0 no effect");
    rd(2'd3, 32'd0, "R10 clear word reads 0");
    cyc(1'b1, 2'd3, 32'h0000_0001, 1'b0, 1'b0);
    rd(2'd2, 32'd0, "R10 status cleared");
    cyc(1'b1, 2'd3, 32'h0000_0001, 1'b0, 1'b1);
    rd(2'd2, 32'd1, "R11 wake beats clear");

    summary();
  end
endmodule